// File: doc/BRIEF.md
# Multi-Input Wake-Up Edge Unit

This unit watches a large set of single-bit event inputs and turns selected transitions or levels into sticky pending flags and per-group interrupt lines. The inputs are arranged as tables. Each table holds a number of groups, and each group holds a fixed number of bits. Every group has its own configuration registers. For each bit, software chooses level or edge detection, any-edge or single-edge, the active polarity, and whether the bit is enabled at all.

Each input first passes through a synchronizer. A per-bit detector then compares the synchronized value with its previous sample. When the programmed condition is met on an enabled bit, the bit's pending flag sets and stays set until software clears it. Software reads pending flags per group and clears them by writing ones to a separate clear register. Each group raises its own interrupt line while any of its pending flags is set.

The register port is a plain write strobe with an address and write data, plus a combinational read path.

Top module: `wkup_unit`

## Requirements
- R1: After reset every configuration register and every pending flag is 0. All interrupt lines are low and every register reads 0.
- R2: Edge mode with rising selection: with mode=0, any=0 and pol=0, a 0-to-1 transition of an enabled input sets its pending flag. A 1-to-0 transition or a steady input does not.
- R3: Edge mode with falling selection: with mode=0, any=0 and pol=1, a 1-to-0 transition sets the pending flag. A 0-to-1 transition does not.
- R4: With mode=0 and any=1, both transitions set the pending flag whatever pol holds. A steady input does not.
- R5: With mode=1, the pending flag is set while the input sits at the active level: high for pol=0, low for pol=1. A clear written while that level persists leaves the flag set. Once the level has gone, a clear removes the flag.
- R6: While a bit's enable flag is 0, no transition or level on its input sets its pending flag.
- R7: Writing the clear register clears exactly the pending bits written as 1. Bits written as 0 keep their value.
- R8: If a detection and a clear of the same bit fall in the same cycle, the pending flag ends up set.
- R9: Each group's interrupt line is high exactly when at least one pending flag of that group is set. Groups do not affect each other's lines.
- R10: A change on an input appears in the pending flag on the third rising clock edge after the change, and not on the second. The path is two synchronizer stages plus the detector.
- R11: The address is {table, group, select}. Select occupies the low 3 bits, with codes 0=mode, 1=any, 2=pol, 3=enable, 4=pending (read-only), 5=clear (write-only, reads 0). The group field is max(1,clog2(GROUPS)) bits and the table field is max(1,clog2(NUM_TABLES)) bits. A write to the pending select changes nothing. A read of an absent table or group returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_TABLES*GROUPS*BITS | Event inputs; bit b of group g in table t is at index (t*GROUPS+g)*BITS+b |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | TW+GW+3 | Register address {table, group, select} |
| reg_wdata | input | BITS | Register write data, one bit per input of the group |
| reg_rdata | output | BITS | Combinational read data for reg_addr |
| irq_o | output | NUM_TABLES*GROUPS | One interrupt line per group, index t*GROUPS+g |

## Verification
The bench builds the unit with two tables of three groups of eight bits. The group count is not a power of two, so the address space contains group codes with no group behind them, and reads to those holes can be checked. Two tables mean the table field takes part in decode. With six interrupt lines, a flag raised in one group can be seen to leave the other five lines untouched. The default synchronizer depth gives an exact three-edge latency that the bench probes on both sides.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

   localparam int unsigned WK_SEL_W = 3;

   typedef enum logic [WK_SEL_W-1:0] {
      WK_MODE = 3'd0,
      WK_ANY  = 3'd1,
      WK_POL  = 3'd2,
      WK_EN   = 3'd3,
      WK_PEND = 3'd4,
      WK_CLR  = 3'd5
   } wk_sel_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wkup_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
      end else begin
         st_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      end
   end

   assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/wkup_detect.sv
module wkup_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic s_i,
   input  logic mode_i,
   input  logic any_i,
   input  logic pol_i,
   input  logic en_i,
   output logic hit_o
);

   logic prev_q;
   logic rise, fall, edge_hit, lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= s_i;
   end

   always_comb begin
      rise     = s_i & ~prev_q;
      fall     = ~s_i & prev_q;
      edge_hit = any_i ? (rise | fall) : (pol_i ? fall : rise);
      lvl_hit  = pol_i ? ~s_i : s_i;
      hit_o    = en_i & (mode_i ? lvl_hit : edge_hit);
   end

endmodule

// File: rtl/wkup_group.sv
module wkup_group
   import wkup_pkg::*;
#(
   parameter int unsigned BITS     = 8,
   parameter int unsigned LEVEL_EN = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BITS-1:0] evt_s,
   input  logic            cfg_we,
   input  wk_sel_e         cfg_sel,
   input  logic [BITS-1:0] wdata,
   input  logic [BITS-1:0] clr_mask,
   output logic [BITS-1:0] mode_o,
   output logic [BITS-1:0] any_o,
   output logic [BITS-1:0] pol_o,
   output logic [BITS-1:0] en_o,
   output logic [BITS-1:0] pend_o,
   output logic [BITS-1:0] hit_o,
   output logic            irq_o
);

   logic [BITS-1:0] mode_q, any_q, pol_q, en_q, pend_q;

   if (LEVEL_EN != 0) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              mode_q <= '0;
         else if (cfg_we && cfg_sel == WK_MODE)   mode_q <= wdata;
      end
   end else begin : g_nolvl
      assign mode_q = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any_q <= '0;
         pol_q <= '0;
         en_q  <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            WK_ANY:  any_q <= wdata;
            WK_POL:  pol_q <= wdata;
            WK_EN:   en_q  <= wdata;
            default: ;
         endcase
      end
   end

   for (genvar b = 0; b < BITS; b++) begin : g_bit
      wkup_detect u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .s_i    (evt_s[b]),
         .mode_i (mode_q[b]),
         .any_i  (any_q[b]),
         .pol_i  (pol_q[b]),
         .en_i   (en_q[b]),
         .hit_o  (hit_o[b])
      );
   end

   // A detection in the same cycle as a clear wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_mask) | hit_o;
   end

   assign mode_o = mode_q;
   assign any_o  = any_q;
   assign pol_o  = pol_q;
   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign irq_o  = |pend_q;

endmodule

// File: rtl/wkup_unit.sv
module wkup_unit
   import wkup_pkg::*;
#(
   parameter int unsigned NUM_TABLES  = 3,
   parameter int unsigned GROUPS      = 8,
   parameter int unsigned BITS        = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEVEL_EN    = 1,
   localparam int unsigned NG  = NUM_TABLES * GROUPS,
   localparam int unsigned NIN = NG * BITS,
   localparam int unsigned TW  = idx_w(NUM_TABLES),
   localparam int unsigned GW  = idx_w(GROUPS),
   localparam int unsigned AW  = TW + GW + WK_SEL_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIN-1:0]  evt_i,
   input  logic            reg_we,
   input  logic [AW-1:0]   reg_addr,
   input  logic [BITS-1:0] reg_wdata,
   output logic [BITS-1:0] reg_rdata,
   output logic [NG-1:0]   irq_o
);

   localparam int unsigned IW = idx_w(NG);

   if (NUM_TABLES < 1 || GROUPS < 1) begin : g_bad_shape
      $error("wkup_unit: NUM_TABLES and GROUPS must be at least 1");
   end
   if (BITS < 1 || BITS > 32) begin : g_bad_bits
      $error("wkup_unit: BITS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wkup_unit: SYNC_STAGES must be at least 2");
   end

   logic [NIN-1:0] evt_s;

   wkup_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (evt_i),
      .q_o   (evt_s)
   );

   // address decode
   logic [TW-1:0] a_tbl;
   logic [GW-1:0] a_grp;
   wk_sel_e       a_sel;
   logic          a_valid;
   logic [IW-1:0] a_idx;

   always_comb begin
      a_tbl   = reg_addr[AW-1 -: TW];
      a_grp   = reg_addr[WK_SEL_W +: GW];
      a_sel   = wk_sel_e'(reg_addr[WK_SEL_W-1:0]);
      a_valid = (int'(a_tbl) < int'(NUM_TABLES)) && (int'(a_grp) < int'(GROUPS));
      a_idx   = IW'(int'(a_tbl) * int'(GROUPS) + int'(a_grp));
   end

   logic [BITS-1:0] mode_a [NG];
   logic [BITS-1:0] any_a  [NG];
   logic [BITS-1:0] pol_a  [NG];
   logic [BITS-1:0] en_a   [NG];
   logic [BITS-1:0] pend_a [NG];
   logic [NIN-1:0]  pend_all, en_all, clr_all, hit_all;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      logic we_g;
      assign we_g = reg_we & a_valid & (a_idx == IW'(g));
      assign clr_all[g*BITS +: BITS] = (we_g && a_sel == WK_CLR) ? reg_wdata : '0;

      wkup_group #(.BITS(BITS), .LEVEL_EN(LEVEL_EN)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_s    (evt_s[g*BITS +: BITS]),
         .cfg_we   (we_g),
         .cfg_sel  (a_sel),
         .wdata    (reg_wdata),
         .clr_mask (clr_all[g*BITS +: BITS]),
         .mode_o   (mode_a[g]),
         .any_o    (any_a[g]),
         .pol_o    (pol_a[g]),
         .en_o     (en_a[g]),
         .pend_o   (pend_a[g]),
         .hit_o    (hit_all[g*BITS +: BITS]),
         .irq_o    (irq_o[g])
      );

      assign pend_all[g*BITS +: BITS] = pend_a[g];
      assign en_all[g*BITS +: BITS]   = en_a[g];
   end

   // read path
   always_comb begin
      reg_rdata = '0;
      if (a_valid) begin
         case (a_sel)
            WK_MODE: reg_rdata = mode_a[a_idx];
            WK_ANY:  reg_rdata = any_a[a_idx];
            WK_POL:  reg_rdata = pol_a[a_idx];
            WK_EN:   reg_rdata = en_a[a_idx];
            WK_PEND: reg_rdata = pend_a[a_idx];
            default: reg_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/wkup_unit_chk.sv
module wkup_unit_chk #(
   parameter int unsigned NGR   = 1,
   parameter int unsigned BITSR = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NGR-1:0]       irq_o,
   input logic [NGR*BITSR-1:0] pend_all,
   input logic [NGR*BITSR-1:0] en_all,
   input logic [NGR*BITSR-1:0] clr_all,
   input logic [NGR*BITSR-1:0] hit_all
);

   // R6: a flag only rises on a bit that was enabled
   p_set_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_all & ~$past(pend_all) & ~$past(en_all)) == '0))
      else $error("p_set_needs_en_r6");

   // R7: a flag only falls when a clear one was written to it
   p_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend_all) & ~pend_all & ~$past(clr_all)) == '0))
      else $error("p_clear_only_r7");

   // R8: a detection always leaves the flag set, clear or not
   p_hit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(hit_all) & ~pend_all) == '0))
      else $error("p_hit_wins_r8");

   for (genvar g = 0; g < NGR; g++) begin : g_irq
      // R9: line follows the group's flags
      p_irq_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[g] == (|pend_all[g*BITSR +: BITSR]))
         else $error("p_irq_or_r9");
   end

endmodule

bind wkup_unit wkup_unit_chk #(.NGR(NG), .BITSR(BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_o    (irq_o),
   .pend_all (pend_all),
   .en_all   (en_all),
   .clr_all  (clr_all),
   .hit_all  (hit_all)
);

// File: tb/wkup_unit_tb_top.sv
`timescale 1ns/1ps
module wkup_unit_tb_top;

   localparam int NT  = 2;
   localparam int G   = 3;
   localparam int B   = 8;
   localparam int NG  = NT * G;
   localparam int NIN = NG * B;
   localparam int AW  = 1 + 2 + 3;

   localparam int S_MODE = 0, S_ANY = 1, S_POL = 2, S_EN = 3, S_PEND = 4, S_CLR = 5;

   // {mode, any, pol, start, end, expected}
   localparam int NV = 12;
   localparam logic [5:0] VEC [NV] = '{
      6'b000011, 6'b000100, 6'b001101, 6'b001010,
      6'b010101, 6'b011011, 6'b010000, 6'b100011,
      6'b101101, 6'b100000, 6'b000110, 6'b011101
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NIN-1:0]  evt;
   logic            reg_we;
   logic [AW-1:0]   reg_addr;
   logic [B-1:0]    reg_wdata;
   logic [B-1:0]    reg_rdata;
   logic [NG-1:0]   irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wkup_unit #(.NUM_TABLES(NT), .GROUPS(G), .BITS(B)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_o     (irq_o)
   );

   function automatic logic [AW-1:0] mk(input int t, input int g, input int s);
      return {t[0], g[1:0], s[2:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int t, input int g, input int s, input logic [B-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = mk(t, g, s); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int t, input int g, input int s, output logic [B-1:0] d);
      @(negedge clk);
      reg_addr = mk(t, g, s);
      #2 d = reg_rdata;
   endtask

   task automatic drive(input int t, input int g, input int b, input logic v);
      @(negedge clk);
      evt[(t*G+g)*B+b] = v;
   endtask

   task automatic quiet_all();
      for (int t = 0; t < NT; t++)
         for (int g = 0; g < G; g++) begin
            wr(t, g, S_EN, '0);
            wr(t, g, S_CLR, '1);
         end
   endtask

   initial begin
      #(20ns * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [B-1:0] r;
      rst_n = 1'b0; evt = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk(irq_o == '0, "R1 irq", irq_o, 0);
      for (int s = 0; s < 6; s++) begin
         rd(1, 2, s, r);
         chk(r == '0, "R1 reg", r, 0);
      end

      // vector table: R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         int t, g, b;
         logic [5:0] v;
         string req;
         v = VEC[i]; t = i % NT; g = i % G; b = i % B;
         req = v[5] ? "R5" : (v[4] ? "R4" : (v[3] ? "R3" : "R2"));
         wr(t, g, S_EN, '0);
         wr(t, g, S_CLR, '1);
         drive(t, g, b, v[2]);
         repeat (4) @(posedge clk);
         wr(t, g, S_MODE, B'(v[5]) << b);
         wr(t, g, S_ANY,  B'(v[4]) << b);
         wr(t, g, S_POL,  B'(v[3]) << b);
         wr(t, g, S_EN,   B'(1) << b);
         wr(t, g, S_CLR, '1);
         drive(t, g, b, v[1]);
         repeat (3) @(posedge clk);
         rd(t, g, S_PEND, r);
         chk(r == (B'(v[0]) << b), req, r, B'(v[0]) << b);
         chk(irq_o[t*G+g] == v[0], {req, " irq"}, irq_o[t*G+g], v[0]);
         drive(t, g, b, 1'b0);
      end
      quiet_all();
      evt = '0;
      repeat (4) @(posedge clk);

      // R11 config readback and read-only pending
      wr(0, 1, S_MODE, 8'hA5);
      rd(0, 1, S_MODE, r);
      chk(r == 8'hA5, "R11 mode readback", r, 8'hA5);
      wr(0, 1, S_PEND, 8'hFF);
      rd(0, 1, S_PEND, r);
      chk(r == 8'h00, "R11 pend read-only", r, 0);
      rd(1, 3, S_MODE, r);
      chk(r == 8'h00, "R11 hole read", r, 0);
      rd(0, 1, S_CLR, r);
      chk(r == 8'h00, "R11 clear reads 0", r, 0);
      wr(0, 1, S_MODE, 8'h00);

      // R6 disabled bit ignores edges
      wr(0, 0, S_EN, 8'hFE);
      drive(0, 0, 0, 1'b1);
      repeat (4) @(posedge clk);
      rd(0, 0, S_PEND, r);
      chk(r == 8'h00, "R6 disabled", r, 0);
      chk(irq_o == '0, "R6 irq", irq_o, 0);
      drive(0, 0, 0, 1'b0);
      wr(0, 0, S_EN, 8'h00);

      // R7 selective clear
      wr(0, 2, S_EN, 8'h06);
      drive(0, 2, 1, 1'b1);
      drive(0, 2, 2, 1'b1);
      repeat (4) @(posedge clk);
      rd(0, 2, S_PEND, r);
      chk(r == 8'h06, "R7 set", r, 8'h06);
      wr(0, 2, S_CLR, 8'h00);
      rd(0, 2, S_PEND, r);
      chk(r == 8'h06, "R7 zero write", r, 8'h06);
      wr(0, 2, S_CLR, 8'h02);
      rd(0, 2, S_PEND, r);
      chk(r == 8'h04, "R7 one bit", r, 8'h04);
      quiet_all();

      // R8 edge coincides with clear
      wr(1, 1, S_EN, 8'h01);
      drive(1, 1, 0, 1'b1);
      repeat (4) @(posedge clk);
      drive(1, 1, 0, 1'b0);
      repeat (4) @(posedge clk);
      rd(1, 1, S_PEND, r);
      chk(r == 8'h01, "R8 pre", r, 8'h01);
      drive(1, 1, 0, 1'b1);
      repeat (2) @(posedge clk);
      wr(1, 1, S_CLR, 8'h01);
      rd(1, 1, S_PEND, r);
      chk(r == 8'h01, "R8 edge beats clear", r, 8'h01);
      wr(1, 1, S_CLR, 8'h01);
      rd(1, 1, S_PEND, r);
      chk(r == 8'h00, "R7 plain clear", r, 0);
      quiet_all();

      // R5 level hold (low active)
      drive(0, 1, 5, 1'b1);
      repeat (4) @(posedge clk);
      wr(0, 1, S_MODE, 8'h20);
      wr(0, 1, S_POL, 8'h20);
      wr(0, 1, S_EN, 8'h20);
      drive(0, 1, 5, 1'b0);
      repeat (4) @(posedge clk);
      wr(0, 1, S_CLR, 8'h20);
      rd(0, 1, S_PEND, r);
      chk(r == 8'h20, "R5 held", r, 8'h20);
      drive(0, 1, 5, 1'b1);
      repeat (4) @(posedge clk);
      wr(0, 1, S_CLR, 8'h20);
      rd(0, 1, S_PEND, r);
      chk(r == 8'h00, "R5 released", r, 0);
      wr(0, 1, S_MODE, 8'h00);
      wr(0, 1, S_POL, 8'h00);
      quiet_all();

      // R9 group isolation
      wr(1, 0, S_EN, 8'h08);
      drive(1, 0, 3, 1'b1);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(irq_o == 6'b001000, "R9 one line", irq_o, 6'b001000);
      quiet_all();
      @(negedge clk);
      chk(irq_o == '0, "R9 cleared", irq_o, 0);

      // R10 latency
      wr(1, 2, S_EN, 8'h80);
      drive(1, 2, 7, 1'b1);
      repeat (2) @(posedge clk);
      rd(1, 2, S_PEND, r);
      chk(r == 8'h00, "R10 not yet", r, 0);
      @(posedge clk);
      rd(1, 2, S_PEND, r);
      chk(r == 8'h80, "R10 third edge", r, 8'h80);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule